// File: doc/BRIEF.md
# Four-Phase Instruction Sequencer

This block paces a small processor core. Every four system clocks form one instruction cycle, and each of the four clocks is marked by its own one-hot phase strobe (T1, T2, T3, T4). In T1 the block issues a read of program memory at the program counter. The returned word is held in a fetch buffer, and at the boundary between T4 and the next T1 it moves into the instruction register. While the next word is being fetched, the word in the instruction register is executed during T2 to T4. In straight-line code this retires one instruction per instruction cycle.

The execute stage may request a change of flow during T4. A request is honoured only when the instruction register holds a valid word. The target then replaces the incremented program counter at the next T1. The word that was prefetched behind the branch is marked invalid, so the change of flow costs exactly one bubble cycle. A stall input freezes the whole sequencer. A T1 synchronisation output gives a quarter-rate, one-high-three-low pulse.

Top module: `phase_pipe_seq`

## Requirements
- R1: The phase output is one-hot with bit 0 = T1, bit 1 = T2, bit 2 = T3 and bit 3 = T4. It advances T1→T2→T3→T4→T1 on every clock in which stall is low.
- R2: t1_sync is high exactly while the phase is T1 and low in T2–T4, which gives a 1:3 high/low ratio at one quarter of the clock rate.
- R3: pm_rd is high only in T1 with stall low, and pm_addr then equals the program counter. Without a taken branch, the program counter increases by one at each T4→T1 boundary.
- R4: At each unstalled T4→T1 boundary, the word returned for that cycle's fetch is loaded into ir and its address into ex_pc. It is executed during the following instruction cycle while the next word is fetched.
- R5: ex_en is high only in T2–T4, with ir_valid high and stall low.
- R6: When br_req is high in an unstalled T4 with ir_valid high, br_tgt is loaded into the program counter at the next T1, and ir_valid is low for that one instruction cycle.
- R7: br_req has no effect outside T4 or while ir_valid is low.
- R8: The program counter wraps from its all-ones value to zero.
- R9: While stall is high, the phase, program counter, t1_sync, ir and ir_valid all hold their values.
- R10: After reset the phase is T1, the program counter is zero and ir_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freezes phase, program counter and instruction register |
| br_req | input | 1 | Change-of-flow request from the execute stage, sampled in T4 |
| br_tgt | input | PC_W | Target address for a change of flow |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | PC_W | Program memory read address (program counter) |
| pm_data | input | IW_W | Program memory read data, valid one clock after pm_rd |
| phase | output | 4 | One-hot phase strobes, T1 in bit 0 |
| t1_sync | output | 1 | Quarter-rate sync pulse, high during T1 |
| ir | output | IW_W | Instruction register |
| ir_valid | output | 1 | Instruction register holds an executable word |
| ex_pc | output | PC_W | Address of the word in the instruction register |
| ex_en | output | 1 | Execute enable for T2–T4 |

## Verification
The properties assume a synchronous program memory that returns data on the clock after pm_rd. They also assume that br_tgt is stable whenever br_req is sampled. The bench's memory model answers every read on the next edge with a value computed from the address. It changes stall, br_req and br_tgt only at the falling edge. The requests are scattered across all phases, across bubble cycles and across stalled cycles. Some targets are chosen next to the top of the address space, so that the properties on flushing, ignored requests and wrap-around all see traffic.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int NUM_PH = 4;
    localparam int PH_T1  = 0;
    localparam int PH_T4  = NUM_PH - 1;
    typedef logic [NUM_PH-1:0] phase_t;
    localparam phase_t PH_RESET = phase_t'(1);
endpackage

// File: rtl/pps_phase_gen.sv
module pps_phase_gen
    import pps_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   advance,
    output phase_t phase,
    output logic   at_t1,
    output logic   at_t4
);
    typedef struct packed {
        phase_t ph;
    } ring_t;

    ring_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (advance) begin
            r_d.ph = {r_q.ph[NUM_PH-2:0], r_q.ph[NUM_PH-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ph: PH_RESET};
        else        r_q <= r_d;
    end

    assign phase = r_q.ph;
    assign at_t1 = r_q.ph[PH_T1];
    assign at_t4 = r_q.ph[PH_T4];
endmodule

// File: rtl/pps_fetch_unit.sv
module pps_fetch_unit #(
    parameter int PC_W = 11,
    parameter int IW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            at_t1,
    input  logic            at_t4,
    input  logic            take_br,
    input  logic [PC_W-1:0] br_tgt,
    input  logic [IW_W-1:0] pm_data,
    output logic            pm_rd,
    output logic [PC_W-1:0] pm_addr,
    output logic [IW_W-1:0] fetch_word,
    output logic [PC_W-1:0] fetch_pc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            rd_pend;
        logic [IW_W-1:0] word;
    } fetch_t;

    fetch_t f_d, f_q;
    logic   boundary;

    assign boundary = at_t4 && advance;
    assign pm_rd    = at_t1 && advance;

    always_comb begin
        f_d         = f_q;
        f_d.rd_pend = pm_rd;
        if (f_q.rd_pend) begin
            f_d.word = pm_data;
        end
        if (boundary) begin
            f_d.pc = take_br ? br_tgt : f_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign pm_addr    = f_q.pc;
    assign fetch_pc   = f_q.pc;
    assign fetch_word = f_q.word;
endmodule

// File: rtl/pps_ir_stage.sv
module pps_ir_stage #(
    parameter int PC_W = 11,
    parameter int IW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            take_br,
    input  logic [IW_W-1:0] fetch_word,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [IW_W-1:0] ir,
    output logic [PC_W-1:0] ir_pc,
    output logic            ir_valid
);
    typedef struct packed {
        logic [IW_W-1:0] word;
        logic [PC_W-1:0] pc;
        logic            valid;
    } irs_t;

    irs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.word  = fetch_word;
            s_d.pc    = fetch_pc;
            s_d.valid = !take_br;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ir       = s_q.word;
    assign ir_pc    = s_q.pc;
    assign ir_valid = s_q.valid;
endmodule

// File: rtl/phase_pipe_seq.sv
module phase_pipe_seq
    import pps_pkg::*;
#(
    parameter int PC_W = 11,
    parameter int IW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              br_req,
    input  logic [PC_W-1:0]   br_tgt,
    output logic              pm_rd,
    output logic [PC_W-1:0]   pm_addr,
    input  logic [IW_W-1:0]   pm_data,
    output logic [NUM_PH-1:0] phase,
    output logic              t1_sync,
    output logic [IW_W-1:0]   ir,
    output logic              ir_valid,
    output logic [PC_W-1:0]   ex_pc,
    output logic              ex_en
);
    logic            advance;
    logic            at_t1;
    logic            at_t4;
    logic            take_br;
    logic [IW_W-1:0] fetch_word;
    logic [PC_W-1:0] fetch_pc;

    assign advance = !stall;
    assign take_br = br_req && ir_valid;

    pps_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .phase   (phase),
        .at_t1   (at_t1),
        .at_t4   (at_t4)
    );

    pps_fetch_unit #(.PC_W(PC_W), .IW_W(IW_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .at_t1      (at_t1),
        .at_t4      (at_t4),
        .take_br    (take_br),
        .br_tgt     (br_tgt),
        .pm_data    (pm_data),
        .pm_rd      (pm_rd),
        .pm_addr    (pm_addr),
        .fetch_word (fetch_word),
        .fetch_pc   (fetch_pc)
    );

    pps_ir_stage #(.PC_W(PC_W), .IW_W(IW_W)) u_ir (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (at_t4 && advance),
        .take_br    (take_br),
        .fetch_word (fetch_word),
        .fetch_pc   (fetch_pc),
        .ir         (ir),
        .ir_pc      (ex_pc),
        .ir_valid   (ir_valid)
    );

    assign t1_sync = at_t1;
    assign ex_en   = ir_valid && !at_t1 && advance;
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int PC_W = 11,
    parameter int IW_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall,
    input logic            br_req,
    input logic [PC_W-1:0] br_tgt,
    input logic            pm_rd,
    input logic [PC_W-1:0] pm_addr,
    input logic [3:0]      phase,
    input logic            t1_sync,
    input logic [IW_W-1:0] ir,
    input logic            ir_valid,
    input logic            ex_en
);
    // R1
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);

    // R1
    phase_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> phase == {$past(phase[2:0]), $past(phase[3])});

    // R2
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t1_sync) |-> $past(phase[3]));

    // R3
    read_in_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd |-> (phase[0] && !stall));

    // R3 R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !stall && !(br_req && ir_valid))
        |=> pm_addr == PC_W'($past(pm_addr) + 1'b1));

    // R5
    exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_en |-> (ir_valid && !phase[0] && !stall));

    // R6
    branch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !stall && br_req && ir_valid)
        |=> (!ir_valid && pm_addr == $past(br_tgt)));

    // R7
    bubble_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase[3] && !stall && !ir_valid) |=> ir_valid);

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(phase) && $stable(pm_addr) && $stable(ir)
                   && $stable(ir_valid) && $stable(t1_sync)));
endmodule

bind phase_pipe_seq pps_checker #(.PC_W(PC_W), .IW_W(IW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .br_req   (br_req),
    .br_tgt   (br_tgt),
    .pm_rd    (pm_rd),
    .pm_addr  (pm_addr),
    .phase    (phase),
    .t1_sync  (t1_sync),
    .ir       (ir),
    .ir_valid (ir_valid),
    .ex_en    (ex_en)
);

// File: tb/sim_phase_pipe_seq.sv
module sim_phase_pipe_seq;
    localparam int PC_W   = 11;
    localparam int IW_W   = 16;
    localparam int PC_MAX = (1 << PC_W) - 1;
    localparam int CYCLES = 4000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            stall;
    logic            br_req;
    logic [PC_W-1:0] br_tgt;
    logic            pm_rd;
    logic [PC_W-1:0] pm_addr;
    logic [IW_W-1:0] pm_data;
    logic [3:0]      phase;
    logic            t1_sync;
    logic [IW_W-1:0] ir;
    logic            ir_valid;
    logic [PC_W-1:0] ex_pc;
    logic            ex_en;

    always #5 clk = ~clk;

    phase_pipe_seq #(.PC_W(PC_W), .IW_W(IW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .br_req(br_req), .br_tgt(br_tgt),
        .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_data(pm_data), .phase(phase),
        .t1_sync(t1_sync), .ir(ir), .ir_valid(ir_valid), .ex_pc(ex_pc), .ex_en(ex_en)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [IW_W-1:0] word_at(int a);
        return IW_W'((a * 40503) ^ 23130 ^ (a >> 3));
    endfunction

    // program memory: synchronous read port
    always @(posedge clk) if (pm_rd) pm_data <= word_at(int'(pm_addr));

    // behavioural reference
    int    m_ph, m_pc, m_irpc;
    bit    m_valid, last_stall, br_seen;
    string pc_tag, iv_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_irpc = 0; m_valid = 0;
            last_stall = 0; br_seen = 0; pc_tag = "R10"; iv_tag = "R10";
        end else begin
            last_stall = stall;
            if (!stall) begin
                if (br_req && m_ph != 3) br_seen = 1;
                if (m_ph == 3) begin
                    bit take, ign;
                    take = br_req && m_valid;
                    ign  = br_req && !m_valid;
                    m_irpc  = m_pc;
                    m_valid = !take;
                    if (take) begin
                        m_pc = int'(br_tgt);
                        pc_tag = "R6";
                    end else begin
                        m_pc = (m_pc == PC_MAX) ? 0 : m_pc + 1;
                        pc_tag = (m_pc == 0) ? "R8" : ((ign || br_seen) ? "R7" : "R3");
                    end
                    iv_tag  = take ? "R6" : (ign ? "R7" : "R4");
                    br_seen = 0;
                end
                m_ph = (m_ph + 1) % 4;
            end
        end
    end

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        string ptag;
        ptag = last_stall ? "R9" : "R1";
        chk(ptag, "phase", longint'(phase), longint'(1 << m_ph));
        chk(last_stall ? "R9" : "R2", "t1_sync", longint'(t1_sync), longint'(m_ph == 0));
        chk(last_stall ? "R9" : pc_tag, "pm_addr", longint'(pm_addr), longint'(m_pc));
        chk("R3", "pm_rd", longint'(pm_rd), longint'(m_ph == 0 && !stall));
        chk(last_stall ? "R9" : iv_tag, "ir_valid", longint'(ir_valid), longint'(m_valid));
        if (m_valid) begin
            chk("R4", "ir", longint'(ir), longint'(word_at(m_irpc)));
            chk("R4", "ex_pc", longint'(ex_pc), longint'(m_irpc));
        end
        chk("R5", "ex_en", longint'(ex_en), longint'(m_valid && m_ph != 0 && !stall));
    endtask

    initial begin
        logic [31:0] r;
        r      = 32'h1234_5678;
        rst_n  = 1'b0;
        stall  = 1'b0;
        br_req = 1'b0;
        br_tgt = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "phase", longint'(phase), 1);
        chk("R10", "pm_addr", longint'(pm_addr), 0);
        chk("R10", "ir_valid", longint'(ir_valid), 0);
        chk("R10", "t1_sync", longint'(t1_sync), 1);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            compare_all();
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            case (cyc / 1000)
                0: begin stall = 1'b0; br_req = 1'b0; end
                1: begin stall = 1'b0; br_req = r[3] & r[4]; end
                2: begin stall = r[0] & r[1]; br_req = 1'b0; end
                default: begin stall = r[0] & r[1] & r[2]; br_req = r[3] & r[4]; end
            endcase
            br_tgt = (r[9:8] == 2'b00) ? PC_W'(PC_MAX - 1) : r[10 +: PC_W];
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule